// File: doc/BRIEF.md
# Sixty-Four-Source Interrupt Controller

This block collects up to 64 active-low interrupt request lines and presents them to a processor as a single interrupt output and a set of 32-bit registers on a simple write/read port. Pending and enable state is stored in a high and a low 32-bit word. Each source number lands on a word and bit through a fixed scrambled table, so software must use that table and not the source number itself. Each line passes through a two-flop synchronizer. Its sense is then fixed by its class: internal lines are level-low; the seven external lines choose between falling edge and level-low; the sixteen port lines choose between falling edge and both edges.

A registered vector field gives software the lowest-numbered source that is both pending and enabled, so a handler can dispatch with one read. Edge-captured requests are cleared by writing ones to the pending words. Register word addresses are: enable high 0, enable low 1, pending high 2, pending low 3, sense 4, vector 5. Addresses 6 and 7 read as zero.

Top module: `irqc64`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is low. Both enable words being zero blocks every source.
- R2: Source s maps to the high word (pending address 2, enable address 0) for s in 0..15 and 32..47, and to the low word (addresses 3 and 1) for the rest. Its bit is 16−s for 1..15, 18−s for 16..18, 33−s for 19..30, 63−s for 32..47, and s−32 for 48..63.
- R3: An enable bit of 1 passes its source and 0 blocks it. `irq_out` is high exactly when some pending bit has its enable bit set, and a blocked source still shows in its pending word.
- R4: Writing a 1 to a bit of a pending word clears an edge-captured request. Writing 0 leaves it unchanged.
- R5: An internal source (every source not listed in R6, R7 or R10) is level-low. Its pending bit follows the synchronized line, and a clear write has no lasting effect while the line stays low.
- R6: External sources 19..25 use sense bit 33−s. A 1 selects falling-edge capture, and a 0 selects level-low as in R5.
- R7: Port sources 48..63 use sense bit s−32. A 1 captures falling edges only, and a 0 captures both rising and falling edges.
- R8: The vector word (address 5) carries in bits 31:26 the lowest-numbered source above 0 that is pending and enabled, or zero if there is none. It changes on the clock edge after the pending or enable change.
- R9: An edge detected in the same cycle as a clear write to that bit leaves the bit set.
- R10: Sources 0 and 31 are reserved. Their lines are ignored and never set a pending bit.
- R11: Only sense bits 8..14 and 16..31 are stored. All other sense bits read as zero.
- R12: A line change reaches the pending word on the third rising clock edge after it is applied, and reaches the vector on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n | input | 64 | Interrupt request lines, active low, indexed by source number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Interrupt request to the processor, active high |

## Verification
The bench walks a table of sources that touches every arm of the mapping, including the ends of each range. A wrong bit formula therefore lights the wrong pending bit, and a wrong word choice lights the other word. It aims a clear write at exactly the cycle in which a port edge is captured: a design that lets the clear win would lose that request. It toggles sense on an external and a port line, so a design that swapped edge and level, or treated both-edge as falling-only, would miss or keep a request. The latency checks count edges on the synchronizer and the vector register: an extra or a missing stage shows up as a pending or vector value one cycle early or late.

// File: rtl/irqc64_pkg.sv
package irqc64_pkg;

    localparam int NSRC   = 64;
    localparam int DW     = 32;
    localparam int AW     = 3;
    localparam int VEC_W  = 6;
    localparam int VEC_LSB = DW - VEC_W;

    localparam logic [AW-1:0] ADDR_EN_HI   = 3'd0;
    localparam logic [AW-1:0] ADDR_EN_LO   = 3'd1;
    localparam logic [AW-1:0] ADDR_PEND_HI = 3'd2;
    localparam logic [AW-1:0] ADDR_PEND_LO = 3'd3;
    localparam logic [AW-1:0] ADDR_SENSE   = 3'd4;
    localparam logic [AW-1:0] ADDR_VEC     = 3'd5;

    typedef enum logic [1:0] {
        KIND_RSVD = 2'd0,
        KIND_INT  = 2'd1,
        KIND_EXT  = 2'd2,
        KIND_PORT = 2'd3
    } src_kind_e;

    function automatic src_kind_e src_kind(input int s);
        if (s == 0 || s == 31)       return KIND_RSVD;
        else if (s >= 19 && s <= 25) return KIND_EXT;
        else if (s >= 48)            return KIND_PORT;
        else                         return KIND_INT;
    endfunction

    function automatic logic src_in_hi(input int s);
        return (s < 16) || (s >= 32 && s < 48);
    endfunction

    function automatic logic [4:0] src_bit(input int s);
        if (s == 0)       return 5'd0;
        else if (s < 16)  return 5'(16 - s);
        else if (s <= 18) return 5'(18 - s);
        else if (s <= 30) return 5'(33 - s);
        else if (s == 31) return 5'd0;
        else if (s < 48)  return 5'(63 - s);
        else              return 5'(s - 32);
    endfunction

    function automatic logic [4:0] sense_bit(input int s);
        if (src_kind(s) == KIND_EXT)       return 5'(33 - s);
        else if (src_kind(s) == KIND_PORT) return 5'(s - 32);
        else                               return 5'd0;
    endfunction

    // Set of live sources that land on a given word/bit position.
    function automatic logic [NSRC-1:0] word_sel(input logic hi, input int b);
        logic [NSRC-1:0] m;
        m = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_kind(s) != KIND_RSVD && src_in_hi(s) == hi && int'(src_bit(s)) == b)
                m[s] = 1'b1;
        end
        return m;
    endfunction

    // Sense bits that belong to a programmable source.
    function automatic logic [DW-1:0] sense_valid();
        logic [DW-1:0] m;
        m = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_kind(s) == KIND_EXT || src_kind(s) == KIND_PORT)
                m[sense_bit(s)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irqc64_src_cell.sv
module irqc64_src_cell
    import irqc64_pkg::*;
#(
    parameter src_kind_e KIND        = KIND_INT,
    parameter int        SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_n_i,
    input  logic edge_sel_i,
    input  logic clr_i,
    output logic pend_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   pend_d;
    logic                   cur;
    logic                   fall;
    logic                   rise;

    assign cur  = sync_q[SYNC_STAGES-1];
    assign fall = prev_q & ~cur;
    assign rise = ~prev_q & cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], src_n_i};
            prev_q <= cur;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        unique case (KIND)
            KIND_RSVD: pend_d = 1'b0;
            KIND_INT:  pend_d = ~cur;
            KIND_EXT:  pend_d = edge_sel_i ? (fall | (pend_q & ~clr_i)) : ~cur;
            KIND_PORT: pend_d = (edge_sel_i ? fall : (fall | rise)) | (pend_q & ~clr_i);
            default:   pend_d = 1'b0;
        endcase
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irqc64_map.sv
module irqc64_map
    import irqc64_pkg::*;
(
    input  logic [NSRC-1:0] pend_src,
    input  logic [DW-1:0]   en_hi,
    input  logic [DW-1:0]   en_lo,
    input  logic [DW-1:0]   sense,
    input  logic            clr_hi_wr,
    input  logic            clr_lo_wr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   pend_hi,
    output logic [DW-1:0]   pend_lo,
    output logic [NSRC-1:0] en_src,
    output logic [NSRC-1:0] edge_sel,
    output logic [NSRC-1:0] clr_src
);

    for (genvar b = 0; b < DW; b++) begin : g_word
        localparam logic [NSRC-1:0] SEL_HI = word_sel(1'b1, b);
        localparam logic [NSRC-1:0] SEL_LO = word_sel(1'b0, b);
        assign pend_hi[b] = |(pend_src & SEL_HI);
        assign pend_lo[b] = |(pend_src & SEL_LO);
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam logic       IS_HI = src_in_hi(s);
        localparam logic [4:0] BIT   = src_bit(s);
        localparam logic [4:0] SBIT  = sense_bit(s);
        if (IS_HI) begin : g_hi
            assign en_src[s]  = en_hi[BIT];
            assign clr_src[s] = clr_hi_wr & wdata[BIT];
        end else begin : g_lo
            assign en_src[s]  = en_lo[BIT];
            assign clr_src[s] = clr_lo_wr & wdata[BIT];
        end
        assign edge_sel[s] = sense[SBIT];
    end

endmodule

// File: rtl/irqc64_regs.sv
module irqc64_regs
    import irqc64_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    pend_hi,
    input  logic [DW-1:0]    pend_lo,
    input  logic [VEC_W-1:0] vec,
    output logic [DW-1:0]    en_hi,
    output logic [DW-1:0]    en_lo,
    output logic [DW-1:0]    sense,
    output logic             clr_hi_wr,
    output logic             clr_lo_wr,
    output logic [DW-1:0]    rdata
);

    localparam logic [DW-1:0] SENSE_KEEP = sense_valid();

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_hi <= '0;
            en_lo <= '0;
            sense <= '0;
        end else if (wr) begin
            if (addr == ADDR_EN_HI) en_hi <= wdata;
            if (addr == ADDR_EN_LO) en_lo <= wdata;
            if (addr == ADDR_SENSE) sense <= wdata & SENSE_KEEP;
        end
    end

    assign clr_hi_wr = wr && (addr == ADDR_PEND_HI);
    assign clr_lo_wr = wr && (addr == ADDR_PEND_LO);

    always_comb begin
        unique case (addr)
            ADDR_EN_HI:   rdata = en_hi;
            ADDR_EN_LO:   rdata = en_lo;
            ADDR_PEND_HI: rdata = pend_hi;
            ADDR_PEND_LO: rdata = pend_lo;
            ADDR_SENSE:   rdata = sense;
            ADDR_VEC:     rdata = {vec, {VEC_LSB{1'b0}}};
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc64_vec.sv
module irqc64_vec
    import irqc64_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend_src,
    input  logic [NSRC-1:0]  en_src,
    output logic [VEC_W-1:0] vec_q
);

    logic [NSRC-1:0]  cand;
    logic [VEC_W-1:0] vec_d;

    assign cand = pend_src & en_src;

    // Walk downward so the lowest live number wins; source 0 never reports.
    always_comb begin
        vec_d = '0;
        for (int s = NSRC - 1; s >= 1; s--) begin
            if (cand[s]) vec_d = VEC_W'(s);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

endmodule

// File: rtl/irqc64.sv
module irqc64
    import irqc64_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq_out
);

    logic [NSRC-1:0]  pend_src;
    logic [NSRC-1:0]  en_src;
    logic [NSRC-1:0]  edge_sel;
    logic [NSRC-1:0]  clr_src;
    logic [DW-1:0]    pend_hi;
    logic [DW-1:0]    pend_lo;
    logic [DW-1:0]    en_hi;
    logic [DW-1:0]    en_lo;
    logic [DW-1:0]    sense_q;
    logic             clr_hi_wr;
    logic             clr_lo_wr;
    logic [VEC_W-1:0] vec_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_cell
        irqc64_src_cell #(
            .KIND        (src_kind(s)),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_n_i    (src_n[s]),
            .edge_sel_i (edge_sel[s]),
            .clr_i      (clr_src[s]),
            .pend_o     (pend_src[s])
        );
    end

    irqc64_map u_map (
        .pend_src  (pend_src),
        .en_hi     (en_hi),
        .en_lo     (en_lo),
        .sense     (sense_q),
        .clr_hi_wr (clr_hi_wr),
        .clr_lo_wr (clr_lo_wr),
        .wdata     (reg_wdata),
        .pend_hi   (pend_hi),
        .pend_lo   (pend_lo),
        .en_src    (en_src),
        .edge_sel  (edge_sel),
        .clr_src   (clr_src)
    );

    irqc64_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .pend_hi   (pend_hi),
        .pend_lo   (pend_lo),
        .vec       (vec_q),
        .en_hi     (en_hi),
        .en_lo     (en_lo),
        .sense     (sense_q),
        .clr_hi_wr (clr_hi_wr),
        .clr_lo_wr (clr_lo_wr),
        .rdata     (reg_rdata)
    );

    irqc64_vec u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_src (pend_src),
        .en_src   (en_src),
        .vec_q    (vec_q)
    );

    assign irq_out = (|(pend_hi & en_hi)) | (|(pend_lo & en_lo));

endmodule

// File: rtl/irqc64_chk.sv
module irqc64_chk
    import irqc64_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [AW-1:0]    reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic             irq_out,
    input logic [DW-1:0]    en_hi,
    input logic [DW-1:0]    en_lo,
    input logic [DW-1:0]    pend_hi,
    input logic [DW-1:0]    sense_q,
    input logic [VEC_W-1:0] vec_q
);

    localparam logic [DW-1:0] KEEP = sense_valid();

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!irq_out && vec_q == '0));

    p_blocked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi == '0 && en_lo == '0) |-> !irq_out);

    p_vec_tracks_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_q != '0) == $past(irq_out));

    p_reserved_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_hi[0] && vec_q != VEC_W'(31)));

    p_sense_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_SENSE) |=> (sense_q == ($past(reg_wdata) & KEEP)));

endmodule

bind irqc64 irqc64_chk u_chk (.*);

// File: tb/irqc64_tb.sv
module irqc64_tb;
    import irqc64_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b1;
    logic [NSRC-1:0] src_n = '1;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irqc64 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_n     (src_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    typedef struct packed {
        logic [5:0] src;
        logic [2:0] addr;
        logic [4:0] bitn;
    } map_vec_t;

    localparam int NV = 14;
    localparam map_vec_t TBL [NV] = '{
        '{6'd1,  3'd2, 5'd15}, '{6'd5,  3'd2, 5'd11}, '{6'd15, 3'd2, 5'd1},
        '{6'd16, 3'd3, 5'd2},  '{6'd18, 3'd3, 5'd0},  '{6'd19, 3'd3, 5'd14},
        '{6'd25, 3'd3, 5'd8},  '{6'd30, 3'd3, 5'd3},  '{6'd32, 3'd2, 5'd31},
        '{6'd40, 3'd2, 5'd23}, '{6'd47, 3'd2, 5'd16}, '{6'd48, 3'd3, 5'd16},
        '{6'd55, 3'd3, 5'd23}, '{6'd63, 3'd3, 5'd31}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(v, exp, tag);
    endtask

    task automatic clear_all();
        wr(ADDR_PEND_HI, '1);
        wr(ADDR_PEND_LO, '1);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        for (int a = 0; a < 8; a++) chk_rd(3'(a), 32'h0, "R1 register after reset");
        chk({31'b0, irq_out}, 32'h0, "R1 irq after reset");

        // R11 sense storage
        wr(ADDR_SENSE, '1);
        chk_rd(ADDR_SENSE, 32'hFFFF_7F00, "R11 sense kept bits");
        wr(ADDR_SENSE, '0);

        // R3 blocked source still pends
        src_n[5] = 1'b0;
        tick(4);
        chk_rd(ADDR_PEND_HI, 32'h0000_0800, "R3 blocked source pending");
        chk({31'b0, irq_out}, 32'h0, "R3 blocked irq");
        chk_rd(ADDR_VEC, 32'h0, "R3 blocked vector");
        wr(ADDR_EN_HI, 32'h0000_0800);
        chk({31'b0, irq_out}, 32'h1, "R3 enabled irq");
        // R5 clear write cannot drop a held level
        wr(ADDR_PEND_HI, 32'h0000_0800);
        tick(1);
        chk_rd(ADDR_PEND_HI, 32'h0000_0800, "R5 level held after clear");
        src_n[5] = 1'b1;
        tick(4);
        chk_rd(ADDR_PEND_HI, 32'h0, "R5 level released");
        chk({31'b0, irq_out}, 32'h0, "R5 irq released");

        // R2 mapping table
        wr(ADDR_EN_HI, '1);
        wr(ADDR_EN_LO, '1);
        for (int i = 0; i < NV; i++) begin
            logic [2:0] other;
            other = (TBL[i].addr == ADDR_PEND_HI) ? ADDR_PEND_LO : ADDR_PEND_HI;
            src_n[TBL[i].src] = 1'b0;
            tick(4);
            chk_rd(TBL[i].addr, 32'h1 << TBL[i].bitn, $sformatf("R2 map source %0d", TBL[i].src));
            chk_rd(other, 32'h0, $sformatf("R2 other word source %0d", TBL[i].src));
            chk_rd(ADDR_VEC, {TBL[i].src, 26'b0}, $sformatf("R8 vector source %0d", TBL[i].src));
            src_n[TBL[i].src] = 1'b1;
            tick(4);
            clear_all();
            tick(1);
        end

        // R12 latency
        src_n[7] = 1'b0;
        tick(2);
        chk_rd(ADDR_PEND_HI, 32'h0, "R12 pending before third edge");
        tick(1);
        chk_rd(ADDR_PEND_HI, 32'h0000_0200, "R12 pending on third edge");
        chk_rd(ADDR_VEC, 32'h0, "R12 vector before fourth edge");
        tick(1);
        chk_rd(ADDR_VEC, {6'd7, 26'b0}, "R12 vector on fourth edge");
        src_n[7] = 1'b1;
        tick(4);

        // R8 priority and one-clock vector update
        src_n[5] = 1'b0; src_n[19] = 1'b0; src_n[40] = 1'b0;
        tick(4);
        chk_rd(ADDR_VEC, {6'd5, 26'b0}, "R8 lowest wins");
        wr(ADDR_EN_HI, 32'hFFFF_F7FF);
        chk_rd(ADDR_VEC, {6'd5, 26'b0}, "R8 vector not yet updated");
        tick(1);
        chk_rd(ADDR_VEC, {6'd19, 26'b0}, "R8 vector after enable change");
        wr(ADDR_EN_HI, '1);
        src_n[5] = 1'b1; src_n[19] = 1'b1; src_n[40] = 1'b1;
        tick(4);
        chk_rd(ADDR_VEC, 32'h0, "R8 vector empty");

        // R6 external source 19, sense bit 14
        wr(ADDR_SENSE, 32'h0000_4000);
        src_n[19] = 1'b0;
        tick(4);
        chk_rd(ADDR_PEND_LO, 32'h0000_4000, "R6 falling edge captured");
        wr(ADDR_PEND_LO, 32'h0000_4000);
        tick(1);
        chk_rd(ADDR_PEND_LO, 32'h0, "R6 edge cleared while low");
        src_n[19] = 1'b1;
        tick(4);
        chk_rd(ADDR_PEND_LO, 32'h0, "R6 rise ignored");
        wr(ADDR_SENSE, 32'h0);
        src_n[19] = 1'b0;
        tick(4);
        wr(ADDR_PEND_LO, 32'h0000_4000);
        tick(1);
        chk_rd(ADDR_PEND_LO, 32'h0000_4000, "R6 level mode holds");
        src_n[19] = 1'b1;
        tick(4);

        // R7 port source 48, sense bit 16; R4 write of zero
        wr(ADDR_SENSE, 32'h0001_0000);
        src_n[48] = 1'b0;
        tick(4);
        chk_rd(ADDR_PEND_LO, 32'h0001_0000, "R7 falling captured");
        wr(ADDR_PEND_LO, 32'h0);
        tick(1);
        chk_rd(ADDR_PEND_LO, 32'h0001_0000, "R4 zero write keeps bit");
        wr(ADDR_PEND_LO, 32'h0001_0000);
        chk_rd(ADDR_PEND_LO, 32'h0, "R4 one write clears");
        src_n[48] = 1'b1;
        tick(4);
        chk_rd(ADDR_PEND_LO, 32'h0, "R7 falling-only ignores rise");
        wr(ADDR_SENSE, 32'h0);
        src_n[48] = 1'b0;
        tick(4);
        wr(ADDR_PEND_LO, 32'h0001_0000);
        src_n[48] = 1'b1;
        tick(4);
        chk_rd(ADDR_PEND_LO, 32'h0001_0000, "R7 both-edge captures rise");
        clear_all();

        // R9 edge and clear in the same cycle (source 50, bit 18)
        wr(ADDR_SENSE, 32'h0004_0000);
        src_n[50] = 1'b0;
        tick(2);
        wr(ADDR_PEND_LO, 32'h0004_0000);
        chk_rd(ADDR_PEND_LO, 32'h0004_0000, "R9 edge beats clear");
        wr(ADDR_PEND_LO, 32'h0004_0000);
        chk_rd(ADDR_PEND_LO, 32'h0, "R9 later clear works");
        src_n[50] = 1'b1;
        tick(4);
        wr(ADDR_SENSE, 32'h0);

        // R10 reserved sources
        src_n[0] = 1'b0; src_n[31] = 1'b0;
        tick(5);
        chk_rd(ADDR_PEND_HI, 32'h0, "R10 source 0 ignored");
        chk_rd(ADDR_PEND_LO, 32'h0, "R10 source 31 ignored");
        chk({31'b0, irq_out}, 32'h0, "R10 irq quiet");
        src_n[0] = 1'b1; src_n[31] = 1'b1;
        tick(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule